// File: doc/BRIEF.md
# Dual-Mode Bank and Chip-Select Decoder

This block is the control side of a one-to-four bus switch. A host-side bus can be connected to one of four output banks, and each bank serves up to eight memory devices through its own chip selects. A single mode input sets how the decode is organised. In wide mode, one active-low enable gates all four banks. A two-bit bank field picks the bank and one three-bit device field picks the chip select inside it. In split mode, the banks form two independent pairs. The lower pair (banks 0 and 1) is gated by the second enable, steered by bank-field bit 0 and addressed by the second device field. The upper pair (banks 2 and 3) is gated by the first enable, steered by bank-field bit 1 and addressed by the first device field. Both pairs can be active at once, and a conflict flag reports when more than one bank is connected.

Read and write strobes are copied to four per-bank outputs that are driven at all times. The data path is modelled one way, from host to bank, as a valid/ready stream. The host offers a word with `host_valid`. `host_ready` is high exactly when at least one bank is connected. A word is taken on a clock edge where both are high, and it is written into the hold register of every connected bank. When no bank is connected, `host_ready` is low, which is the back-pressure: the host must keep its word and `host_valid` until a route opens. A bank that is not connected keeps its last value.

Top module: `bank_cs_switch`

## Requirements
- R1: In wide mode (`mode`=0) with `ram_en_n` low, `bank_conn` is one-hot, and its set bit is bit `bank_sel`.
- R2: In wide mode, the only low chip select is bit 8*`bank_sel`+`sel_a` of `cs_n` (bank k owns bits 8k..8k+7, and field value n selects index n). `rom_en_n` has no effect in wide mode.
- R3: In split mode (`mode`=1) with `rom_en_n` low, bank `bank_sel[0]` is connected, and chip select 8*`bank_sel[0]`+`sel_b` is low. With `rom_en_n` high, banks 0 and 1 are unconnected and their chip selects are all high.
- R4: In split mode with `ram_en_n` low, bank 2+`bank_sel[1]` is connected, and chip select 8*(2+`bank_sel[1]`)+`sel_a` is low. With `ram_en_n` high, banks 2 and 3 are unconnected and their chip selects are all high.
- R5: When no enable applies (both high, or `ram_en_n` high in wide mode), `bank_conn` is 0 and all 32 chip selects are 1.
- R6: `rd_out` and `wr_out` are four copies of `rd_in` and `wr_in`, whatever the mode, enables and selects.
- R7: `conflict` is high exactly when more than one bit of `bank_conn` is set. This happens only in split mode with both enables low.
- R8: `host_ready` equals OR of `bank_conn`. On a rising edge with `host_valid` and `host_ready` high, every connected bank's output (`bank_data[64k+63:64k]`) takes `host_data` after that edge.
- R9: A bank output changes only on an accepted transfer that connects it. Unconnected banks, and all banks when `host_valid` is low, hold their value.
- R10: A synchronous active-high `rst` clears all four bank outputs to 0 on the next rising edge. The decode and strobe outputs are combinational and are not affected by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank hold registers |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 = wide mode, 1 = split mode |
| ram_en_n | input | 1 | Active-low enable: all banks (wide) or upper pair (split) |
| rom_en_n | input | 1 | Active-low enable for the lower pair in split mode |
| sel_a | input | 3 | Device field for wide mode and the upper pair |
| sel_b | input | 3 | Device field for the lower pair in split mode |
| bank_sel | input | 2 | Bank field |
| rd_in | input | 1 | Read strobe in |
| wr_in | input | 1 | Write strobe in |
| host_data | input | 64 | Host word |
| host_valid | input | 1 | Host word offered |
| host_ready | output | 1 | A bank is connected; word can be taken |
| bank_conn | output | 4 | Bank-connect enables |
| cs_n | output | 32 | Active-low chip selects, 8 per bank |
| rd_out | output | 4 | Per-bank read strobe copies |
| wr_out | output | 4 | Per-bank write strobe copies |
| conflict | output | 1 | More than one bank connected |
| bank_data | output | 256 | Four 64-bit bank outputs, bank k in bits 64k+63:64k |

## Verification
In split mode, the two pair decoders can fire in the same cycle. Then two banks are connected, two chip selects are low and one host word lands in two hold registers, while `conflict` rises. The random stimulus sets both enables low about a quarter of the time, and directed cases cover both pairs with every combination of the bank bits. The expected connect vector, chip selects, conflict flag and the four hold registers come from bench functions. The registers are compared after every edge.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int NUM_BANKS   = 4;
  localparam int CS_PER_BANK = 8;
  localparam int SEL_W       = $clog2(CS_PER_BANK);
  localparam int BANK_W      = $clog2(NUM_BANKS);
  localparam int CS_TOTAL    = NUM_BANKS * CS_PER_BANK;
  localparam int PAIR_SIZE   = NUM_BANKS / 2;

  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } sw_mode_e;
endpackage

// File: rtl/bsw_decode.sv
module bsw_decode
  import bsw_pkg::*;
(
  input  logic                mode,
  input  logic                ram_en_n,
  input  logic                rom_en_n,
  input  logic [SEL_W-1:0]    sel_a,
  input  logic [SEL_W-1:0]    sel_b,
  input  logic [BANK_W-1:0]   bank_sel,
  output logic [NUM_BANKS-1:0] conn,
  output logic [CS_TOTAL-1:0] cs_n
);
  sw_mode_e mode_e;
  assign mode_e = sw_mode_e'(mode);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    logic             pick;
    logic [SEL_W-1:0] field;

    if (k < PAIR_SIZE) begin : g_lo
      always_comb begin
        if (mode_e == MODE_WIDE) begin
          pick  = !ram_en_n && (bank_sel == BANK_W'(k));
          field = sel_a;
        end else begin
          pick  = !rom_en_n && (bank_sel[0] == 1'(k % 2));
          field = sel_b;
        end
      end
    end else begin : g_hi
      always_comb begin
        if (mode_e == MODE_WIDE) begin
          pick  = !ram_en_n && (bank_sel == BANK_W'(k));
          field = sel_a;
        end else begin
          pick  = !ram_en_n && (bank_sel[1] == 1'(k % 2));
          field = sel_a;
        end
      end
    end

    assign conn[k] = pick;

    for (genvar j = 0; j < CS_PER_BANK; j++) begin : g_cs
      assign cs_n[k*CS_PER_BANK + j] = !(pick && (field == SEL_W'(j)));
    end
  end
endmodule

// File: rtl/bsw_strobe_fan.sv
module bsw_strobe_fan #(
  parameter int COPIES = 4
) (
  input  logic              rd_in,
  input  logic              wr_in,
  output logic [COPIES-1:0] rd_out,
  output logic [COPIES-1:0] wr_out
);
  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    assign rd_out[i] = rd_in;
    assign wr_out[i] = wr_in;
  end
endmodule

// File: rtl/bsw_bank_hold.sv
module bsw_bank_hold #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/bank_cs_switch.sv
module bank_cs_switch
  import bsw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode,
  input  logic                          ram_en_n,
  input  logic                          rom_en_n,
  input  logic [SEL_W-1:0]              sel_a,
  input  logic [SEL_W-1:0]              sel_b,
  input  logic [BANK_W-1:0]             bank_sel,
  input  logic                          rd_in,
  input  logic                          wr_in,
  input  logic [DATA_W-1:0]             host_data,
  input  logic                          host_valid,
  output logic                          host_ready,
  output logic [NUM_BANKS-1:0]          bank_conn,
  output logic [CS_TOTAL-1:0]           cs_n,
  output logic [NUM_BANKS-1:0]          rd_out,
  output logic [NUM_BANKS-1:0]          wr_out,
  output logic                          conflict,
  output logic [NUM_BANKS*DATA_W-1:0]   bank_data
);
  logic accept;

  bsw_decode u_decode (
    .mode     (mode),
    .ram_en_n (ram_en_n),
    .rom_en_n (rom_en_n),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .bank_sel (bank_sel),
    .conn     (bank_conn),
    .cs_n     (cs_n)
  );

  bsw_strobe_fan #(.COPIES(NUM_BANKS)) u_fan (
    .rd_in  (rd_in),
    .wr_in  (wr_in),
    .rd_out (rd_out),
    .wr_out (wr_out)
  );

  assign host_ready = |bank_conn;
  assign conflict   = ($countones(bank_conn) > 1);
  assign accept     = host_valid && host_ready;

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_hold
    bsw_bank_hold #(.DATA_W(DATA_W)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (accept && bank_conn[k]),
      .din  (host_data),
      .dout (bank_data[k*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker
  import bsw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        mode,
  input logic                        ram_en_n,
  input logic                        rom_en_n,
  input logic                        rd_in,
  input logic                        wr_in,
  input logic [DATA_W-1:0]           host_data,
  input logic                        host_valid,
  input logic                        host_ready,
  input logic [NUM_BANKS-1:0]        bank_conn,
  input logic [CS_TOTAL-1:0]         cs_n,
  input logic [NUM_BANKS-1:0]        rd_out,
  input logic [NUM_BANKS-1:0]        wr_out,
  input logic                        conflict,
  input logic [NUM_BANKS*DATA_W-1:0] bank_data
);
  a_r1_wide_onehot: assert property (@(posedge clk) disable iff (rst)
    (mode == 1'b0 && !ram_en_n) |-> ($countones(bank_conn) == 1));

  a_r2_cs_matches_conn: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) == $countones(bank_conn));

  a_r5_idle: assert property (@(posedge clk) disable iff (rst)
    (ram_en_n && (rom_en_n || mode == 1'b0)) |-> (bank_conn == '0 && (&cs_n)));

  a_r6_strobe_copy: assert property (@(posedge clk) disable iff (rst)
    (rd_out == {NUM_BANKS{rd_in}}) && (wr_out == {NUM_BANKS{wr_in}}));

  a_r7_no_conflict_wide: assert property (@(posedge clk) disable iff (rst)
    (mode == 1'b0) |-> !conflict);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_chk
    a_r8_write: assert property (@(posedge clk) disable iff (rst)
      (host_valid && host_ready && bank_conn[k]) |=>
        (bank_data[k*DATA_W +: DATA_W] == $past(host_data)));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !(host_valid && bank_conn[k]) |=> $stable(bank_data[k*DATA_W +: DATA_W]));
  end
endmodule

bind bank_cs_switch bsw_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .ram_en_n   (ram_en_n),
  .rom_en_n   (rom_en_n),
  .rd_in      (rd_in),
  .wr_in      (wr_in),
  .host_data  (host_data),
  .host_valid (host_valid),
  .host_ready (host_ready),
  .bank_conn  (bank_conn),
  .cs_n       (cs_n),
  .rd_out     (rd_out),
  .wr_out     (wr_out),
  .conflict   (conflict),
  .bank_data  (bank_data)
);

// File: tb/sim_bank_cs_switch.sv
module sim_bank_cs_switch;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          mode, ram_en_n, rom_en_n;
  logic [2:0]    sel_a, sel_b;
  logic [1:0]    bank_sel;
  logic          rd_in, wr_in;
  logic [DW-1:0] host_data;
  logic          host_valid;
  logic          host_ready;
  logic [3:0]    bank_conn;
  logic [31:0]   cs_n;
  logic [3:0]    rd_out, wr_out;
  logic          conflict;
  logic [4*DW-1:0] bank_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [4];

  always #10 clk = ~clk;

  bank_cs_switch #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .ram_en_n(ram_en_n), .rom_en_n(rom_en_n),
    .sel_a(sel_a), .sel_b(sel_b), .bank_sel(bank_sel), .rd_in(rd_in), .wr_in(wr_in),
    .host_data(host_data), .host_valid(host_valid), .host_ready(host_ready),
    .bank_conn(bank_conn), .cs_n(cs_n), .rd_out(rd_out), .wr_out(wr_out),
    .conflict(conflict), .bank_data(bank_data)
  );

  function automatic logic [3:0] exp_conn();
    logic [3:0] c = '0;
    if (!mode) begin
      if (!ram_en_n) c[bank_sel] = 1'b1;
    end else begin
      if (!rom_en_n) c[{1'b0, bank_sel[0]}] = 1'b1;
      if (!ram_en_n) c[{1'b1, bank_sel[1]}] = 1'b1;
    end
    return c;
  endfunction

  function automatic logic [31:0] exp_cs();
    logic [31:0] v = '1;
    if (!mode) begin
      if (!ram_en_n) v[{bank_sel, sel_a}] = 1'b0;
    end else begin
      if (!rom_en_n) v[{1'b0, bank_sel[0], sel_b}] = 1'b0;
      if (!ram_en_n) v[{1'b1, bank_sel[1], sel_a}] = 1'b0;
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_comb(input string tag);
    logic [3:0] c = exp_conn();
    chk({tag, " R1/R3/R4 conn"}, DW'(bank_conn), DW'(c));
    chk({tag, " R2/R5 cs_n"}, DW'(cs_n), DW'(exp_cs()));
    chk({tag, " R6 strobes"}, DW'({rd_out, wr_out}), DW'({{4{rd_in}}, {4{wr_in}}}));
    chk({tag, " R7 conflict"}, DW'(conflict), DW'($countones(c) > 1));
    chk({tag, " R8 ready"}, DW'(host_ready), DW'(|c));
  endtask

  task automatic check_data(input string tag);
    for (int k = 0; k < 4; k++)
      chk({tag, " R8/R9/R10 bank data"}, bank_data[k*DW +: DW], model[k]);
  endtask

  // Inputs already driven; check decode, clock once, then check hold registers.
  task automatic cycle(input string tag);
    logic [3:0] c;
    #1;
    check_comb(tag);
    c = exp_conn();
    @(posedge clk);
    if (rst) for (int k = 0; k < 4; k++) model[k] = '0;
    else if (host_valid && |c)
      for (int k = 0; k < 4; k++) if (c[k]) model[k] = host_data;
    #1;
    check_data(tag);
    @(negedge clk);
  endtask

  task automatic drive(input logic m, input logic ra, input logic ro, input logic [2:0] a,
                       input logic [2:0] b, input logic [1:0] bk, input logic v);
    mode = m; ram_en_n = ra; rom_en_n = ro; sel_a = a; sel_b = b; bank_sel = bk;
    host_valid = v;
    host_data = {$urandom, $urandom};
    rd_in = 1'($urandom); wr_in = 1'($urandom);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) model[k] = '0;
    rst = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 3'd0, 3'd0, 2'd0, 1'b0);
    @(negedge clk);
    cycle("reset R10");
    cycle("reset R10");
    rst = 1'b0;

    // R1/R2: wide mode, every bank and device, rom enable toggled (ignored)
    for (int bk = 0; bk < 4; bk++)
      for (int s = 0; s < 8; s++) begin
        drive(1'b0, 1'b0, 1'(s % 2), 3'(s), 3'(7 - s), 2'(bk), 1'b1);
        cycle("wide R1 R2");
      end
    // R5: wide mode with only rom enable low -> idle; R9 hold with valid high
    drive(1'b0, 1'b1, 1'b0, 3'd3, 3'd4, 2'd2, 1'b1);
    cycle("wide idle R5 R9");
    // R3/R4/R7: split mode all enable and bank-bit combos
    for (int en = 0; en < 4; en++)
      for (int bk = 0; bk < 4; bk++) begin
        drive(1'b1, 1'(en[0]), 1'(en[1]), 3'(bk + 1), 3'(6 - bk), 2'(bk), 1'b1);
        cycle("split R3 R4 R7");
      end
    // R9: valid low, both pairs on
    drive(1'b1, 1'b0, 1'b0, 3'd1, 3'd2, 2'd3, 1'b0);
    cycle("valid low R9");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      rst = ($urandom_range(0, 99) == 0);
      drive(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 3'($urandom),
            2'($urandom), 1'($urandom_range(0, 3) != 0));
      cycle("random");
    end
    rst = 1'b0;

    // R10 reset during a transfer wins
    drive(1'b1, 1'b0, 1'b0, 3'd5, 3'd5, 2'd1, 1'b1);
    cycle("pre-reset R8");
    rst = 1'b1;
    cycle("reset mid-traffic R10");
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule